// File: doc/BRIEF.md
# Bridge Address Window Decoder

This block sits on the downstream side of a bus bridge and decides whether a transaction should be claimed and forwarded across the bridge. It holds four address windows: two memory windows and two I/O windows. Each window has a lower-bound register and an upper-bound register. A 32-bit configuration port, addressed by dword index, programs the windows and a small control register. The control register marks each memory window as prefetchable or not.

For each transaction the block takes an address and a memory-or-I/O type flag. From these it gives a claim flag, the index of the window that matched and a prefetchable indication, all in the same cycle. A memory window works on 4-Kbyte blocks. An I/O window works on dwords: its upper 16 bits select a 64-Kbyte page and its lower 16 bits give the position within that page. A window whose lower and upper bounds are both zero is switched off, so nothing is claimed after reset.

The configuration read data is combinational from the offset. Writes take effect at the rising clock edge on which `cfg_wr_en` is high.

Top module: `bridge_window_decoder`

## Requirements
- R1: After a synchronous active-low reset, every configuration offset reads 0 and no transaction of either type is claimed.
- R2: The memory bound registers keep bits 31:12 as written. Bits 11:0 always read 0, and writes to them are lost.
- R3: The I/O bound registers keep bits 31:2 as written. Bits 1:0 always read 0.
- R4: The registers sit at these dword indices (byte offset divided by 4):
  - 7: memory window 0 lower bound
  - 8: memory window 0 upper bound
  - 9: memory window 1 lower bound
  - 10: memory window 1 upper bound
  - 11: I/O window 0 lower bound
  - 12: I/O window 0 upper bound
  - 13: I/O window 1 lower bound
  - 14: I/O window 1 upper bound
  - 15: control register
- R5: A window whose lower and upper bounds are both zero never claims.
- R6: A memory window matches when lower[31:12] <= addr[31:12] <= upper[31:12]. The whole upper 4-Kbyte block is included.
- R7: An I/O window matches when lower[31:2] <= addr[31:2] <= upper[31:2]. The whole upper dword is included.
- R8: A memory transaction (`txn_is_io`=0) consults only the memory windows. An I/O transaction (`txn_is_io`=1) consults only the I/O windows.
- R9: `claim` is high when any consulted window matches. `win_idx` gives the matching window, and window 0 wins when both match.
- R10: Control register bits 8 and 9 mark memory windows 0 and 1 as prefetchable. These are the only bits the control register holds; its other bits read 0. `win_prefetch` is the bit of the winning window on a memory claim and is 0 on an I/O claim.
- R11: Reading an offset not listed in R4 returns 0. Writing such an offset changes no register.
- R12: While `claim` is low, `win_idx` and `win_prefetch` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_offset | input | 6 | Configuration dword index |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for `cfg_offset` |
| txn_addr | input | 32 | Transaction address |
| txn_is_io | input | 1 | 1 = I/O transaction, 0 = memory transaction |
| claim | output | 1 | Transaction falls in an enabled window of its type |
| win_idx | output | 1 | Index of the winning window |
| win_prefetch | output | 1 | Winning memory window is prefetchable |

## Verification
The hardest cases to reach from the ports are exact window edges where two windows overlap. The same address must then lie on one window's bound and inside the other, with the type flag and the enable rule deciding which window wins. The stimulus programs several window layouts: disjoint, overlapping, one window switched off with the other starting at address zero, and inverted bounds. For each layout it sweeps addresses at every bound minus and plus two granules, using the first and last byte of each granule. The expected claim, index and prefetch values come from an arithmetic model of the shadowed register contents.

// File: rtl/bwd_pkg.sv
// Shared constants for the bridge window decoder.
// Assumes a 32-bit configuration data path and a dword-indexed offset.
package bwd_pkg;
    localparam int NWIN       = 2;
    localparam int AW         = 32;
    localparam int OFFS_W     = 6;
    localparam int MEM_LSB    = 12;
    localparam int IO_LSB     = 2;
    localparam int IDX_W      = (NWIN > 1) ? $clog2(NWIN) : 1;
    localparam int OFF_MEM0   = 7;   // memory lower/upper pairs start here
    localparam int OFF_IO0    = 11;  // I/O lower/upper pairs start here
    localparam int OFF_CTRL   = 15;  // prefetch control register
    localparam int PF_BIT0    = 8;   // prefetch bit of window 0
endpackage

// File: rtl/bwd_cfg_regs.sv
// Configuration register file: window bounds and prefetch bits.
// Holds only the writable bits; the fixed-zero low bits are added on output.
// Assumes offsets as laid out in bwd_pkg and a single write strobe.
module bwd_cfg_regs
    import bwd_pkg::*;
#(
    parameter int A_W  = AW,
    parameter int O_W  = OFFS_W,
    parameter int M_LO = MEM_LSB,
    parameter int I_LO = IO_LSB
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [O_W-1:0]            offset,
    input  logic [A_W-1:0]            wdata,
    output logic [A_W-1:0]            rdata,
    output logic [NWIN-1:0][A_W-1:0]  mem_lo,
    output logic [NWIN-1:0][A_W-1:0]  mem_hi,
    output logic [NWIN-1:0][A_W-1:0]  io_lo,
    output logic [NWIN-1:0][A_W-1:0]  io_hi,
    output logic [NWIN-1:0]           pf
);
    logic [NWIN-1:0] pf_q;

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        localparam logic [O_W-1:0] O_MLO = O_W'(OFF_MEM0 + 2*w);
        localparam logic [O_W-1:0] O_MHI = O_W'(OFF_MEM0 + 2*w + 1);
        localparam logic [O_W-1:0] O_ILO = O_W'(OFF_IO0 + 2*w);
        localparam logic [O_W-1:0] O_IHI = O_W'(OFF_IO0 + 2*w + 1);
        logic [A_W-1:M_LO] mlo_q, mhi_q;
        logic [A_W-1:I_LO] ilo_q, ihi_q;

        // Capture writable bits of this window's bound registers.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mlo_q <= '0;
                mhi_q <= '0;
                ilo_q <= '0;
                ihi_q <= '0;
            end else if (wr_en) begin
                if (offset == O_MLO) mlo_q <= wdata[A_W-1:M_LO];
                if (offset == O_MHI) mhi_q <= wdata[A_W-1:M_LO];
                if (offset == O_ILO) ilo_q <= wdata[A_W-1:I_LO];
                if (offset == O_IHI) ihi_q <= wdata[A_W-1:I_LO];
            end
        end

        assign mem_lo[w] = {mlo_q, {M_LO{1'b0}}};
        assign mem_hi[w] = {mhi_q, {M_LO{1'b0}}};
        assign io_lo[w]  = {ilo_q, {I_LO{1'b0}}};
        assign io_hi[w]  = {ihi_q, {I_LO{1'b0}}};
    end

    // Capture the prefetch bits from the control register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pf_q <= '0;
        else if (wr_en && offset == O_W'(OFF_CTRL))
            pf_q <= wdata[PF_BIT0 +: NWIN];
    end

    assign pf = pf_q;

    // Return the addressed register; unmapped offsets give zero.
    always_comb begin
        rdata = '0;
        for (int w = 0; w < NWIN; w++) begin
            if (offset == O_W'(OFF_MEM0 + 2*w))     rdata = mem_lo[w];
            if (offset == O_W'(OFF_MEM0 + 2*w + 1)) rdata = mem_hi[w];
            if (offset == O_W'(OFF_IO0 + 2*w))      rdata = io_lo[w];
            if (offset == O_W'(OFF_IO0 + 2*w + 1))  rdata = io_hi[w];
        end
        if (offset == O_W'(OFF_CTRL))
            rdata[PF_BIT0 +: NWIN] = pf_q;
    end
endmodule

// File: rtl/bwd_range_cmp.sv
// Inclusive range comparator for one window at a given granularity.
// The window is off while both bounds are zero; bits below LSB are ignored.
module bwd_range_cmp #(
    parameter int A_W = 32,
    parameter int LSB = 12
) (
    input  logic [A_W-1:0] lo,
    input  logic [A_W-1:0] hi,
    input  logic [A_W-1:0] addr,
    output logic           hit
);
    logic enabled;
    logic above_lo;
    logic below_hi;

    // Compare the granule numbers against both bounds.
    always_comb begin
        enabled  = (|lo) || (|hi);
        above_lo = addr[A_W-1:LSB] >= lo[A_W-1:LSB];
        below_hi = addr[A_W-1:LSB] <= hi[A_W-1:LSB];
        hit      = enabled && above_lo && below_hi;
    end
endmodule

// File: rtl/bwd_claim_sel.sv
// Picks the winning window for the transaction type, lowest index first.
// Outputs are zero when nothing matches.
module bwd_claim_sel
    import bwd_pkg::*;
#(
    parameter int N   = NWIN,
    parameter int I_W = IDX_W
) (
    input  logic [N-1:0]   mem_hit,
    input  logic [N-1:0]   io_hit,
    input  logic [N-1:0]   pf,
    input  logic           is_io,
    output logic           claim,
    output logic [I_W-1:0] idx,
    output logic           prefetch
);
    logic [N-1:0] hits;

    // Scan from the top so the lowest matching index is kept.
    always_comb begin
        hits     = is_io ? io_hit : mem_hit;
        claim    = 1'b0;
        idx      = '0;
        prefetch = 1'b0;
        for (int w = N - 1; w >= 0; w--) begin
            if (hits[w]) begin
                claim    = 1'b1;
                idx      = I_W'(w);
                prefetch = !is_io && pf[w];
            end
        end
    end
endmodule

// File: rtl/bridge_window_decoder.sv
// Top of the bridge window decoder: register file, one comparator per
// window and type, and the priority selector. The decode is combinational
// from the address and type inputs.
module bridge_window_decoder
    import bwd_pkg::*;
#(
    parameter int A_W = AW,
    parameter int O_W = OFFS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [O_W-1:0]   cfg_offset,
    input  logic [A_W-1:0]   cfg_wdata,
    output logic [A_W-1:0]   cfg_rdata,
    input  logic [A_W-1:0]   txn_addr,
    input  logic             txn_is_io,
    output logic             claim,
    output logic [IDX_W-1:0] win_idx,
    output logic             win_prefetch
);
    logic [NWIN-1:0][A_W-1:0] mem_lo, mem_hi, io_lo, io_hi;
    logic [NWIN-1:0]          pf;
    logic [NWIN-1:0]          mem_hit, io_hit;

    bwd_cfg_regs #(.A_W(A_W), .O_W(O_W), .M_LO(MEM_LSB), .I_LO(IO_LSB)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_wr_en),
        .offset (cfg_offset),
        .wdata  (cfg_wdata),
        .rdata  (cfg_rdata),
        .mem_lo (mem_lo),
        .mem_hi (mem_hi),
        .io_lo  (io_lo),
        .io_hi  (io_hi),
        .pf     (pf)
    );

    for (genvar w = 0; w < NWIN; w++) begin : g_cmp
        bwd_range_cmp #(.A_W(A_W), .LSB(MEM_LSB)) u_mem (
            .lo   (mem_lo[w]),
            .hi   (mem_hi[w]),
            .addr (txn_addr),
            .hit  (mem_hit[w])
        );
        bwd_range_cmp #(.A_W(A_W), .LSB(IO_LSB)) u_io (
            .lo   (io_lo[w]),
            .hi   (io_hi[w]),
            .addr (txn_addr),
            .hit  (io_hit[w])
        );
    end

    bwd_claim_sel #(.N(NWIN), .I_W(IDX_W)) u_sel (
        .mem_hit  (mem_hit),
        .io_hit   (io_hit),
        .pf       (pf),
        .is_io    (txn_is_io),
        .claim    (claim),
        .idx      (win_idx),
        .prefetch (win_prefetch)
    );
endmodule

// File: rtl/bwd_decoder_chk.sv
// Assertion checker for bridge_window_decoder, attached by bind.
// Observes only the top-level ports.
module bwd_decoder_chk
    import bwd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_en,
    input logic [OFFS_W-1:0] cfg_offset,
    input logic [AW-1:0]     cfg_wdata,
    input logic [AW-1:0]     cfg_rdata,
    input logic [AW-1:0]     txn_addr,
    input logic              txn_is_io,
    input logic              claim,
    input logic [IDX_W-1:0]  win_idx,
    input logic              win_prefetch
);
    logic is_mem_off, is_io_off, is_unmapped;

    // Classify the current configuration offset.
    always_comb begin
        is_mem_off  = cfg_offset >= OFFS_W'(OFF_MEM0) && cfg_offset < OFFS_W'(OFF_IO0);
        is_io_off   = cfg_offset >= OFFS_W'(OFF_IO0) && cfg_offset < OFFS_W'(OFF_CTRL);
        is_unmapped = cfg_offset < OFFS_W'(OFF_MEM0) || cfg_offset > OFFS_W'(OFF_CTRL);
    end

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (cfg_rdata == '0 && !claim));
    p_mem_low_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        is_mem_off |-> cfg_rdata[MEM_LSB-1:0] == '0);
    p_io_low_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        is_io_off |-> cfg_rdata[IO_LSB-1:0] == '0);
    p_io_no_prefetch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && txn_is_io) |-> !win_prefetch);
    p_ctrl_bits_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_offset == OFFS_W'(OFF_CTRL)) |-> $countones(cfg_rdata) <= NWIN);
    p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        is_unmapped |-> cfg_rdata == '0);
    p_idle_outputs_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !claim |-> (win_idx == '0 && !win_prefetch));
endmodule

bind bridge_window_decoder bwd_decoder_chk u_chk (.*);

// File: tb/bridge_window_decoder_test.sv
module bridge_window_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [5:0]  cfg_offset = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [31:0] txn_addr = '0;
    logic        txn_is_io = 1'b0;
    logic        claim;
    logic [0:0]  win_idx;
    logic        win_prefetch;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    // Shadow of programmed state, already masked to the writable bits.
    logic [31:0] sh_mlo [2];
    logic [31:0] sh_mhi [2];
    logic [31:0] sh_ilo [2];
    logic [31:0] sh_ihi [2];
    logic [1:0]  sh_pf;

    bridge_window_decoder uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_offset(cfg_offset),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .txn_addr(txn_addr),
        .txn_is_io(txn_is_io), .claim(claim), .win_idx(win_idx),
        .win_prefetch(win_prefetch)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: got %0d cycles exp fewer", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        total = total + 1;
        if (got !== exp) begin
            bad = bad + 1;
            $display("FAIL %s %s: got %h exp %h", req, what, got, exp);
        end
    endtask

    task automatic wr(input int off, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_offset = 6'(off);
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input int off, input logic [31:0] exp);
        @(negedge clk);
        cfg_offset = 6'(off);
        #1;
        chk(req, $sformatf("read off %0d", off), cfg_rdata, exp);
    endtask

    function automatic logic [31:0] read_mask(input int off);
        if (off >= 7 && off <= 10) return 32'hFFFF_F000;   // R2
        if (off >= 11 && off <= 14) return 32'hFFFF_FFFC;  // R3
        if (off == 15) return 32'h0000_0300;               // R10
        return 32'h0;                                      // R11
    endfunction

    // Expected claim/index/prefetch from the shadowed windows.
    task automatic model(input logic [31:0] a, input logic io,
                         output logic c, output logic ix, output logic p);
        c = 0; ix = 0; p = 0;
        for (int w = 1; w >= 0; w--) begin
            logic [31:0] lo, hi;
            int sh;
            lo = io ? sh_ilo[w] : sh_mlo[w];
            hi = io ? sh_ihi[w] : sh_mhi[w];
            sh = io ? 2 : 12;
            if ((lo != 0 || hi != 0) && (a >> sh) >= (lo >> sh) && (a >> sh) <= (hi >> sh)) begin
                c = 1; ix = w[0]; p = !io && sh_pf[w];
            end
        end
    endtask

    task automatic probe(input string req, input logic [31:0] a, input logic io);
        logic ec, ei, ep;
        model(a, io, ec, ei, ep);
        @(negedge clk);
        txn_addr = a;
        txn_is_io = io;
        #1;
        chk(req, $sformatf("claim a=%h io=%0d", a, io), 32'(claim), 32'(ec));
        chk("R9", $sformatf("idx a=%h io=%0d", a, io), 32'(win_idx), 32'(ei));
        chk("R10", $sformatf("pf a=%h io=%0d", a, io), 32'(win_prefetch), 32'(ep));
        if (!claim) chk("R12", "idle idx", 32'(win_idx), 32'h0);
    endtask

    task automatic program_all(input logic [31:0] m0l, input logic [31:0] m0h,
                               input logic [31:0] m1l, input logic [31:0] m1h,
                               input logic [31:0] i0l, input logic [31:0] i0h,
                               input logic [31:0] i1l, input logic [31:0] i1h,
                               input logic [1:0] pfb);
        sh_mlo[0] = m0l & 32'hFFFF_F000; sh_mhi[0] = m0h & 32'hFFFF_F000;
        sh_mlo[1] = m1l & 32'hFFFF_F000; sh_mhi[1] = m1h & 32'hFFFF_F000;
        sh_ilo[0] = i0l & 32'hFFFF_FFFC; sh_ihi[0] = i0h & 32'hFFFF_FFFC;
        sh_ilo[1] = i1l & 32'hFFFF_FFFC; sh_ihi[1] = i1h & 32'hFFFF_FFFC;
        sh_pf = pfb;
        wr(7, m0l);  wr(8, m0h);  wr(9, m1l);  wr(10, m1h);
        wr(11, i0l); wr(12, i0h); wr(13, i1l); wr(14, i1h);
        wr(15, {22'h0, pfb, 8'h0});
    endtask

    // Sweep each bound of each window at -2..+2 granules, first and last byte.
    task automatic sweep(input string req_m, input string req_i);
        for (int t = 0; t < 2; t++) begin
            logic io;
            int g;
            io = t[0];
            g = io ? 4 : 4096;
            for (int w = 0; w < 2; w++) begin
                for (int e = 0; e < 2; e++) begin
                    logic [31:0] b;
                    if (io) b = e ? sh_ihi[w] : sh_ilo[w];
                    else    b = e ? sh_mhi[w] : sh_mlo[w];
                    for (int d = -2; d <= 2; d++) begin
                        logic [31:0] a;
                        a = b + 32'(d * g);
                        probe(io ? req_i : req_m, a, io);
                        probe(io ? req_i : req_m, a + 32'(g - 1), io);
                    end
                end
            end
            probe(io ? req_i : req_m, 32'h0, io);
            probe(io ? req_i : req_m, 32'hFFFF_FFFF, io);
        end
    endtask

    initial begin
        for (int w = 0; w < 2; w++) begin
            sh_mlo[w] = 0; sh_mhi[w] = 0; sh_ilo[w] = 0; sh_ihi[w] = 0;
        end
        sh_pf = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: every offset reads zero and nothing claims after reset.
        for (int o = 0; o < 64; o++) rd_chk("R1", o, 32'h0);
        probe("R1", 32'h0000_0000, 1'b0);
        probe("R1", 32'h0000_0000, 1'b1);
        probe("R1", 32'h1234_5678, 1'b0);
        probe("R1", 32'hFFFF_FFFC, 1'b1);

        // R2 R3 R4 R10: all-ones and a pattern land only in writable bits.
        for (int o = 7; o <= 15; o++) wr(o, 32'hFFFF_FFFF);
        for (int o = 7; o <= 15; o++) rd_chk(o < 11 ? "R2" : (o < 15 ? "R3" : "R10"), o, read_mask(o));
        for (int o = 7; o <= 15; o++) wr(o, 32'hA5A5_A5A5 ^ 32'(o));
        for (int o = 7; o <= 15; o++) rd_chk("R4", o, (32'hA5A5_A5A5 ^ 32'(o)) & read_mask(o));

        // R11: unmapped writes change nothing, unmapped reads give zero.
        for (int o = 0; o < 64; o++) if (o < 7 || o > 15) wr(o, 32'hFFFF_FFFF);
        for (int o = 0; o < 64; o++) if (o < 7 || o > 15) rd_chk("R11", o, 32'h0);
        for (int o = 7; o <= 15; o++) rd_chk("R11", o, (32'hA5A5_A5A5 ^ 32'(o)) & read_mask(o));

        // Disjoint windows; low bits written as ones are dropped.
        program_all(32'h1000_0ABC, 32'h1000_0FFF, 32'h2000_0000, 32'h2000_3000,
                    32'h0001_2343, 32'h0001_2380, 32'h0003_0000, 32'h0003_0010, 2'b01);
        sweep("R6", "R7");
        // Overlapping windows: window 0 must win.
        program_all(32'h4000_0000, 32'h4000_5000, 32'h4000_2000, 32'h4000_8000,
                    32'h0000_1000, 32'h0000_1040, 32'h0000_1020, 32'h0000_1080, 2'b10);
        sweep("R9", "R9");
        // Window 0 off; window 1 starts at zero (enabled by its upper bound).
        program_all(32'h0, 32'h0, 32'h0, 32'h0000_3000,
                    32'h0, 32'h0, 32'h0, 32'h0000_0010, 2'b11);
        sweep("R5", "R5");
        // Overlap with I/O addresses sharing memory values: type decides (R8).
        program_all(32'h0000_1000, 32'h0000_1000, 32'h0, 32'h0,
                    32'h0000_8000, 32'h0000_8FFC, 32'h0, 32'h0, 2'b01);
        probe("R8", 32'h0000_1004, 1'b1);
        probe("R8", 32'h0000_1004, 1'b0);
        probe("R8", 32'h0000_8004, 1'b0);
        probe("R8", 32'h0000_8004, 1'b1);
        // Inverted bounds: nothing claims.
        program_all(32'h0000_5000, 32'h0000_2000, 32'h9000_0000, 32'h8000_0000,
                    32'h0000_0100, 32'h0000_0080, 32'h0000_4000, 32'h0000_3000, 2'b11);
        sweep("R6", "R7");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule